// File: doc/BRIEF.md
# 72-bit SECDED Hamming Codec

This block protects 64-bit words with a (72,64) Hamming code that corrects any one flipped bit and detects any two. One side is an encoder: it takes a 64-bit data word and produces the 72-bit codeword. The other side is a decoder: it takes a 72-bit codeword, possibly damaged, and returns the recovered 64 data bits. Two flags go with the data. `sec` reports that a single error was repaired. `ded` reports an uncorrectable error.

The codeword layout is fixed. The whole-word parity bit sits at position 0. The seven Hamming check bits sit at the power-of-two positions 1, 2, 4, 8, 16, 32 and 64. Data bits fill every other position in rising order. All check bits use even parity.

Both paths have no internal state. The `REG_OUT` parameter optionally places one register stage after them, and that stage is cleared by an asynchronous active-low reset. The two paths are independent, so a word can be encoded and a different word decoded in the same cycle.

Top module: `secded_codec`

## Requirements
- R1: Hamming check bit j sits at codeword position 2^j, and the whole-word parity bit sits at position 0. Data bit k takes the k-th position, counting upward from 3, that is not 0 and not a power of two. So d0 is at 3, d4 at 9, d56 at 63, d57 at 65 and d63 at 71. For example, data with only d0 set encodes to 72'hF, and data with only d63 set encodes to bits 71, 64, 4, 2, 1 and 0.
- R2: For each j, the XOR of every codeword position whose index has bit j set is 0. This includes the check bit's own position.
- R3: The XOR of all 72 codeword bits is 0.
- R4: A codeword with no error decodes to its original data, with `sec`=0 and `ded`=0.
- R5: A codeword with exactly one flipped bit at any position from 1 to 71, including a check bit, decodes to the original data with `sec`=1 and `ded`=0.
- R6: A codeword whose only flipped bit is position 0 decodes with `sec`=1 and `ded`=0, and the data bits are unchanged.
- R7: A codeword with exactly two flipped bits gives `ded`=1 and `sec`=0. `data_out` then carries the received data bits without correction.
- R8: When the received word has odd overall parity and its syndrome points above position 71, the decoder gives `ded`=1 and `sec`=0 and returns the uncorrected data bits. Flipping positions 0, 8 and 64 gives syndrome 72.
- R9: With `REG_OUT`=1, every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R10: `sec` and `ded` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 64 | Data word to encode |
| code_out | output | 72 | Encoded codeword |
| code_in | input | 72 | Received codeword to decode |
| data_out | output | 64 | Corrected (or, on `ded`, raw) data bits |
| sec | output | 1 | Single error corrected |
| ded | output | 1 | Uncorrectable error detected |

## Verification
The bench builds the block with the default `DATA_W`=64 and `REG_OUT`=1, so every result appears exactly one clock after its input. With these values the code has 72 positions and a 7-bit syndrome. This makes it possible to sweep a single flip over every position, and it also makes the unused syndromes 72 to 127 reachable through three chosen flips. The hand-computed codewords for d0, d4 and d63 pin down the exact bit layout at this width.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Number of Hamming check bits needed for dw data bits (overall parity excluded).
    function automatic int hbits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic bit is_pow2(input int x);
        return (x != 0) && ((x & (x - 1)) == 0);
    endfunction

    // Codeword position of data bit k: k-th index >= 1 that is not a power of two.
    function automatic int data_pos(input int k);
        int cnt;
        cnt = 0;
        for (int p = 1; p < 4096; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == k) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DATA_W = 64,
    localparam int PAR_W = secded_pkg::hbits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    logic [CODE_W-1:0] body;
    logic              acc;

    always_comb begin
        body = '0;
        for (int i = 0; i < DATA_W; i++) begin
            body[secded_pkg::data_pos(i)] = data_in[i];
        end
        // check bit positions are still zero here, so each group sum excludes them
        for (int j = 0; j < PAR_W; j++) begin
            acc = 1'b0;
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (pos[j]) acc = acc ^ body[pos];
            end
            body[1 << j] = acc;
        end
        body[0] = ^body[CODE_W-1:1];
        code_out = body;
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 64,
    localparam int PAR_W = secded_pkg::hbits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              sec,
    output logic              ded
);
    logic [PAR_W-1:0]  syn;
    logic              odd;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int j = 0; j < PAR_W; j++) begin
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (pos[j]) syn[j] = syn[j] ^ code_in[pos];
            end
        end
        odd   = ^code_in;
        fixed = code_in;
        sec   = 1'b0;
        ded   = 1'b0;
        if (syn == '0) begin
            sec = odd;                        // only the overall bit flipped
        end else if (odd && (int'(syn) <= CODE_W - 1)) begin
            sec        = 1'b1;
            fixed[syn] = ~fixed[syn];
        end else begin
            ded = 1'b1;                       // even parity pair, or out-of-range pointer
        end
        for (int i = 0; i < DATA_W; i++) begin
            data_out[i] = fixed[secded_pkg::data_pos(i)];
        end
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
    parameter int DATA_W = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int PAR_W = secded_pkg::hbits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out,
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              sec,
    output logic              ded
);
    logic [CODE_W-1:0] enc_word;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sec;
    logic              dec_ded;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_in  (data_in),
        .code_out (enc_word)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .code_in  (code_in),
        .data_out (dec_data),
        .sec      (dec_sec),
        .ded      (dec_ded)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code_out <= '0;
                    data_out <= '0;
                    sec      <= 1'b0;
                    ded      <= 1'b0;
                end else begin
                    code_out <= enc_word;
                    data_out <= dec_data;
                    sec      <= dec_sec;
                    ded      <= dec_ded;
                end
            end
        end else begin : g_comb
            assign code_out = enc_word;
            assign data_out = dec_data;
            assign sec      = dec_sec;
            assign ded      = dec_ded;
        end
    endgenerate
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
    parameter int DATA_W = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int PAR_W = secded_pkg::hbits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_out,
    input logic [CODE_W-1:0] code_in,
    input logic [DATA_W-1:0] data_out,
    input logic              sec,
    input logic              ded
);
    logic [DATA_W-1:0] raw_now;
    logic [DATA_W-1:0] raw_ref;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) raw_now[i] = code_in[secded_pkg::data_pos(i)];
    end

    generate
        if (REG_OUT) begin : g_ref
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) raw_ref <= '0;
                else        raw_ref <= raw_now;
            end
        end else begin : g_ref_c
            assign raw_ref = raw_now;
        end
    endgenerate

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec && ded));

    a_r3_even_word: assert property (@(posedge clk) disable iff (!rst_n)
        (^code_out) == 1'b0);

    a_r4_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec && !ded) |-> (data_out == raw_ref));

    a_r7_ded_keeps_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ded |-> (data_out == raw_ref));

    a_r5_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
        sec |-> ($countones(data_out ^ raw_ref) <= 1));
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_out (code_out),
    .code_in  (code_in),
    .data_out (data_out),
    .sec      (sec),
    .ded      (ded)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
    localparam int DW = 64;
    localparam int PW = 7;
    localparam int CW = DW + PW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] code_in = '0;
    logic [CW-1:0] code_out;
    logic [DW-1:0] data_out;
    logic          sec;
    logic          ded;

    always #4 clk = ~clk;

    secded_codec u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .code_out(code_out),
        .code_in(code_in), .data_out(data_out), .sec(sec), .ded(ded)
    );

    typedef struct {
        logic [CW-1:0] code;
        logic [DW-1:0] data;
        logic          sec;
        logic          ded;
        bit            enc_chk;
        string         req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;

    function automatic bit pow2(input int x);
        return (x != 0) && ((x & (x - 1)) == 0);
    endfunction

    function automatic int b_syn(input logic [CW-1:0] w);
        int s = 0;
        for (int pos = 1; pos < CW; pos++) if (w[pos]) s = s ^ pos;
        return s;
    endfunction

    function automatic logic [CW-1:0] b_enc(input logic [DW-1:0] d);
        logic [CW-1:0] w = '0;
        int k = 0;
        int s;
        for (int pos = 3; pos < CW; pos++) begin
            if (!pow2(pos)) begin
                w[pos] = d[k];
                k++;
            end
        end
        s = b_syn(w);
        for (int j = 0; j < PW; j++) w[1 << j] = s[j];
        w[0] = ^w;
        return w;
    endfunction

    function automatic logic [DW-1:0] b_raw(input logic [CW-1:0] w);
        logic [DW-1:0] d = '0;
        int k = 0;
        for (int pos = 3; pos < CW; pos++) begin
            if (!pow2(pos)) begin
                d[k] = w[pos];
                k++;
            end
        end
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [DW-1:0] d, input logic [CW-1:0] exp_code,
                        input logic [CW-1:0] cin, input logic [DW-1:0] exp_data,
                        input logic exp_sec, input logic exp_ded, input bit enc_chk,
                        input string req);
        item_t it;
        @(negedge clk);
        data_in = d;
        code_in = cin;
        it.code = exp_code;
        it.data = exp_data;
        it.sec = exp_sec;
        it.ded = exp_ded;
        it.enc_chk = enc_chk;
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: results appear one edge after the driving negedge (R9)
    always @(posedge clk) begin
        #2;
        if (!finished && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(code_out == it.code, it.req, "code_out", code_out, it.code);
            check(data_out == it.data, it.req, "data_out", {8'h0, data_out}, {8'h0, it.data});
            check({sec, ded} == {it.sec, it.ded}, it.req, "sec/ded",
                  {70'h0, sec, ded}, {70'h0, it.sec, it.ded});
            check(!(sec && ded), "R10", "flags both set", {70'h0, sec, ded}, 72'h0);
            if (it.enc_chk)
                check(b_syn(code_out) == 0 && (^code_out) == 1'b0, "R2/R3",
                      "parity groups", code_out, it.code);
        end
    end

    task automatic clean(input logic [DW-1:0] d, input string req);
        logic [CW-1:0] c = b_enc(d);
        send(d, c, c, d, 1'b0, 1'b0, 1'b1, req);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [CW-1:0] c;
        logic [CW-1:0] e;
        // R9: outputs held at zero during reset even with live inputs
        data_in = '1;
        code_in = 72'h12_3456_789A_BCDE_F012;
        repeat (3) @(negedge clk);
        check(code_out == '0 && data_out == '0 && !sec && !ded, "R9", "reset state",
              code_out, 72'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 layout against hand-worked codewords
        send(64'h1, 72'hF, 72'hF, 64'h1, 1'b0, 1'b0, 1'b1, "R1 d0");
        send(64'h10, 72'h303, 72'h303, 64'h10, 1'b0, 1'b0, 1'b1, "R1 d4");
        send(64'h8000_0000_0000_0000, 72'h81_0000_0000_0000_0017,
             72'h81_0000_0000_0000_0017, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, "R1 d63");

        // R4 clean words of various patterns (R2, R3 checked on every code_out)
        clean('0, "R4 zero");
        clean('1, "R4 ones");
        clean(64'hA5A5_5A5A_F00F_0FF0, "R4 pattern");
        for (int n = 0; n < 6; n++) clean({$urandom, $urandom}, "R4 random");

        // R5 single flip at each position, R6 for position 0
        d = 64'hC3D2_E1F0_0123_4567;
        c = b_enc(d);
        for (int pos = 0; pos < CW; pos++) begin
            e = c;
            e[pos] = ~e[pos];
            send(d, c, e, d, 1'b1, 1'b0, 1'b0, (pos == 0) ? "R6 p0 flip" : "R5 single");
        end

        // R7 double flips: raw data bits returned
        for (int n = 0; n < 8; n++) begin
            int a = (n * 13 + 5) % CW;
            int b = (n * 29 + 40) % CW;
            if (a == b) b = (b + 1) % CW;
            d = {$urandom, $urandom};
            c = b_enc(d);
            e = c;
            e[a] = ~e[a];
            e[b] = ~e[b];
            send(d, c, e, b_raw(e), 1'b0, 1'b1, 1'b0, "R7 double");
        end

        // R8 syndrome beyond last position with odd parity
        d = 64'h0F1E_2D3C_4B5A_6978;
        c = b_enc(d);
        e = c;
        e[0] = ~e[0]; e[8] = ~e[8]; e[64] = ~e[64];
        send(d, c, e, b_raw(e), 1'b0, 1'b1, 1'b0, "R8 syn72");
        e = c;
        e[1] = ~e[1]; e[8] = ~e[8]; e[64] = ~e[64];
        send(d, c, e, b_raw(e), 1'b0, 1'b1, 1'b0, "R8 syn73");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule